// File: doc/BRIEF.md
# Status-Register Poll Matcher

This block automates waiting on a serial flash device. Once started, it asks an attached command sequencer for a status read, one read at a time. Each returned status word is tested against a programmable mask and reference value. Between reads it waits a programmable number of clock cycles. A hit sets a sticky flag for software. The block can then either stop on its own or keep polling until it is aborted or disabled.

The status word is one to four bytes wide, and only the received bytes are tested. Two tests are available. The first needs every selected bit to equal its reference bit. The second needs at least one selected bit to equal its reference bit. The serial protocol itself belongs to the sequencer. This block only exchanges a request pulse with the sequencer and receives a status word with a valid strobe.

Top module: `status_poll_matcher`

## Requirements
- R1: While `rst_n` is low and directly after its release, `busy`, `rd_req` and `match_flag` are 0.
- R2: A `poll_start` pulse with `enable` high and the block idle raises `busy` and gives a one-cycle `rd_req` in the next cycle. Only one read is outstanding at a time, and `rd_req` never rises while `busy` is low.
- R3: `cfg_len` = k (0..3) means k+1 status bytes are received, with byte i on `rd_status[8i+7:8i]`. Bytes above k take no part in the test, whatever their mask.
- R4: With `cfg_or_mode` = 0, a read hits when every compared bit equals its `cfg_match` bit. A compared bit is a `cfg_mask` bit at 1 inside a received byte. A read with no compared bits hits.
- R5: With `cfg_or_mode` = 1, a read hits when at least one compared bit equals its `cfg_match` bit. A read with no compared bits does not hit.
- R6: After a read returns without ending the poll, the next `rd_req` follows after exactly `cfg_gap` idle cycles. With `cfg_gap` = 0 it comes in the very next cycle.
- R7: With `cfg_auto_stop` = 1, a hit drops `busy` in the next cycle, and no further `rd_req` is issued.
- R8: With `cfg_auto_stop` = 0, polling continues after a hit, and every hitting read sets `match_flag` again.
- R9: `match_flag` stays at 1 until a `flag_clear` pulse. If a hit and `flag_clear` fall in the same cycle, the flag ends up set.
- R10: If `poll_abort` arrives while a read is outstanding, it is held until that read returns, and `busy` falls in the next cycle. If it arrives during the gap between reads, `busy` falls in the next cycle.
- R11: `enable` low sends the block idle in the next cycle. While `enable` is low, `poll_start` is ignored.
- R12: A `rd_valid` that arrives while no read is outstanding, or while `enable` is low, does not change `match_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Block enable; low forces idle |
| poll_start | input | 1 | Start polling (pulse) |
| poll_abort | input | 1 | End polling at the next read boundary (pulse) |
| cfg_mask | input | 32 | 1 selects a status bit for the test |
| cfg_match | input | 32 | Reference value for the selected bits |
| cfg_len | input | 2 | Received status bytes minus one |
| cfg_or_mode | input | 1 | 0: all selected bits must equal; 1: any one suffices |
| cfg_auto_stop | input | 1 | Stop polling on the first hit |
| cfg_gap | input | 16 | Idle cycles between a returned read and the next request |
| rd_req | output | 1 | One-cycle request for a status read |
| rd_valid | input | 1 | Status word valid strobe |
| rd_status | input | 32 | Returned status word |
| flag_clear | input | 1 | Clears `match_flag` |
| match_flag | output | 1 | Sticky hit flag |
| busy | output | 1 | Polling in progress |

## Verification
The assertions check, on every cycle, that requests are single-cycle pulses and never appear while idle. They also check that `enable` low empties the block, that a hit with automatic stop ends the poll, and that the flag is set on every hit, holds until cleared and rises only after an accepted read. Only the bench scenarios can show that the test results themselves are correct. These cover the byte-length window, both combination modes including the case with no compared bits, the exact gap length, the deferred abort and the stray strobes that must be ignored.

// File: rtl/spm_pkg.sv
package spm_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2,
    ST_GAP  = 2'd3
  } poll_state_e;

  localparam int DEF_STATUS_BYTES = 4;
  localparam int DEF_GAP_W        = 16;
endpackage

// File: rtl/spm_compare.sv
module spm_compare #(
  parameter int BYTES = 4,
  parameter int LEN_W = 2
) (
  input  logic [8*BYTES-1:0] status,
  input  logic [8*BYTES-1:0] mask,
  input  logic [8*BYTES-1:0] ref_val,
  input  logic [LEN_W-1:0]   len,
  input  logic               or_mode,
  output logic               hit
);
  logic [BYTES-1:0] lane_all;
  logic [BYTES-1:0] lane_any;

  for (genvar g = 0; g < BYTES; g++) begin : g_lane
    logic       lane_on;
    logic [7:0] sel;
    logic [7:0] same;
    // a lane is received when its index does not exceed the length code
    assign lane_on     = (len >= LEN_W'(g));
    assign sel         = mask[8*g +: 8] & {8{lane_on}};
    assign same        = ~(status[8*g +: 8] ^ ref_val[8*g +: 8]);
    assign lane_all[g] = &(same | ~sel);
    assign lane_any[g] = |(same & sel);
  end

  assign hit = or_mode ? (|lane_any) : (&lane_all);
endmodule

// File: rtl/spm_gap_timer.sv
module spm_gap_timer #(
  parameter int GAP_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [GAP_W-1:0] load_val,
  input  logic             run,
  output logic             done
);
  logic [GAP_W-1:0] cnt_q;
  logic [GAP_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (load) begin
      cnt_d  = load_val;
      cnt_en = 1'b1;
    end else if (run && (cnt_q != '0)) begin
      cnt_d  = cnt_q - 1'b1;
      cnt_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign done = (cnt_q == GAP_W'(1));
endmodule

// File: rtl/spm_poll_fsm.sv
module spm_poll_fsm
  import spm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start,
  input  logic abort,
  input  logic rd_valid,
  input  logic hit,
  input  logic auto_stop,
  input  logic gap_zero,
  input  logic gap_done,
  output logic load_gap,
  output logic in_gap,
  output logic wait_st,
  output logic hit_event,
  output logic rd_req,
  output logic busy
);
  poll_state_e state_q, state_d;
  logic        abort_q, abort_d;
  logic        abort_eff;

  assign abort_eff = abort_q | abort;

  always_comb begin
    state_d  = state_q;
    load_gap = 1'b0;
    if (!enable) begin
      state_d = ST_IDLE;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start) state_d = ST_REQ;
        ST_REQ:  state_d = ST_WAIT;
        ST_WAIT: begin
          if (rd_valid) begin
            if (hit && auto_stop)  state_d = ST_IDLE;
            else if (abort_eff)    state_d = ST_IDLE;
            else if (gap_zero)     state_d = ST_REQ;
            else begin
              state_d  = ST_GAP;
              load_gap = 1'b1;
            end
          end
        end
        ST_GAP: begin
          if (abort_eff)     state_d = ST_IDLE;
          else if (gap_done) state_d = ST_REQ;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_comb begin
    abort_d = abort_q;
    if (!enable || (state_q == ST_IDLE)) abort_d = 1'b0;
    else if (abort)                      abort_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      abort_q <= 1'b0;
    end else begin
      state_q <= state_d;
      abort_q <= abort_d;
    end
  end

  assign wait_st   = (state_q == ST_WAIT);
  assign in_gap    = (state_q == ST_GAP);
  assign hit_event = enable && wait_st && rd_valid && hit;
  assign rd_req    = (state_q == ST_REQ);
  assign busy      = (state_q != ST_IDLE);
endmodule

// File: rtl/status_poll_matcher.sv
module status_poll_matcher #(
  parameter int STATUS_BYTES = spm_pkg::DEF_STATUS_BYTES,
  parameter int GAP_W        = spm_pkg::DEF_GAP_W,
  localparam int SW          = 8 * STATUS_BYTES,
  localparam int LEN_W       = (STATUS_BYTES > 1) ? $clog2(STATUS_BYTES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic             poll_start,
  input  logic             poll_abort,
  input  logic [SW-1:0]    cfg_mask,
  input  logic [SW-1:0]    cfg_match,
  input  logic [LEN_W-1:0] cfg_len,
  input  logic             cfg_or_mode,
  input  logic             cfg_auto_stop,
  input  logic [GAP_W-1:0] cfg_gap,
  output logic             rd_req,
  input  logic             rd_valid,
  input  logic [SW-1:0]    rd_status,
  input  logic             flag_clear,
  output logic             match_flag,
  output logic             busy
);
  logic cmp_hit;
  logic fsm_wait;
  logic fsm_gap;
  logic hit_event;
  logic load_gap;
  logic gap_done;
  logic flag_q, flag_d, flag_en;

  spm_compare #(.BYTES(STATUS_BYTES), .LEN_W(LEN_W)) u_cmp (
    .status  (rd_status),
    .mask    (cfg_mask),
    .ref_val (cfg_match),
    .len     (cfg_len),
    .or_mode (cfg_or_mode),
    .hit     (cmp_hit)
  );

  spm_gap_timer #(.GAP_W(GAP_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load_gap),
    .load_val (cfg_gap),
    .run      (fsm_gap),
    .done     (gap_done)
  );

  spm_poll_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .start     (poll_start),
    .abort     (poll_abort),
    .rd_valid  (rd_valid),
    .hit       (cmp_hit),
    .auto_stop (cfg_auto_stop),
    .gap_zero  (cfg_gap == '0),
    .gap_done  (gap_done),
    .load_gap  (load_gap),
    .in_gap    (fsm_gap),
    .wait_st   (fsm_wait),
    .hit_event (hit_event),
    .rd_req    (rd_req),
    .busy      (busy)
  );

  // a hit in the same cycle as a clear wins
  always_comb begin
    flag_d  = flag_q;
    flag_en = 1'b0;
    if (hit_event) begin
      flag_d  = 1'b1;
      flag_en = 1'b1;
    end else if (flag_clear) begin
      flag_d  = 1'b0;
      flag_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_en) begin
      flag_q <= flag_d;
    end
  end

  assign match_flag = flag_q;
endmodule

// File: rtl/spm_checker.sv
module spm_checker (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic rd_req,
  input logic busy,
  input logic rd_valid,
  input logic match_flag,
  input logic flag_clear,
  input logic hit,
  input logic wait_st,
  input logic auto_stop
);
  assert_req_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> !rd_req);

  assert_idle_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req);

  assert_auto_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_st && rd_valid && enable && hit && auto_stop) |=> !busy);

  assert_flag_on_hit_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wait_st && rd_valid && enable && hit) |=> match_flag);

  assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (match_flag && !flag_clear) |=> match_flag);

  assert_disable_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !busy);

  assert_flag_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(match_flag) |-> $past(rd_valid && wait_st && enable));
endmodule

bind status_poll_matcher spm_checker u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .enable     (enable),
  .rd_req     (rd_req),
  .busy       (busy),
  .rd_valid   (rd_valid),
  .match_flag (match_flag),
  .flag_clear (flag_clear),
  .hit        (cmp_hit),
  .wait_st    (fsm_wait),
  .auto_stop  (cfg_auto_stop)
);

// File: tb/status_poll_matcher_test.sv
module status_poll_matcher_test;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;

  // {mask, match, status, len, or_mode, expected hit}
  localparam logic [99:0] VEC [NVEC] = '{
    {32'hFFFF_FFFF, 32'h1234_5678, 32'h1234_5678, 2'd3, 1'b0, 1'b1},
    {32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 2'd3, 1'b0, 1'b0},
    {32'h0000_0001, 32'h0000_0000, 32'hFFFF_FFFE, 2'd3, 1'b0, 1'b1},
    {32'hFFFF_FFFF, 32'h0000_00A5, 32'h5A5A_5AA5, 2'd0, 1'b0, 1'b1},
    {32'hFFFF_FFFF, 32'h0000_00A5, 32'h5A5A_5AA5, 2'd1, 1'b0, 1'b0},
    {32'h0000_F000, 32'h0000_F000, 32'h0000_1000, 2'd3, 1'b1, 1'b1},
    {32'h0000_00FF, 32'h0000_00FF, 32'h0000_0000, 2'd3, 1'b1, 1'b0},
    {32'hFF00_0000, 32'h0000_0000, 32'h0000_0000, 2'd0, 1'b1, 1'b0},
    {32'hFF00_0000, 32'hFFFF_FFFF, 32'h0000_0000, 2'd0, 1'b0, 1'b1},
    {32'h00FF_0000, 32'h0080_0000, 32'h0080_0000, 2'd2, 1'b1, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        enable, poll_start, poll_abort;
  logic [31:0] cfg_mask, cfg_match, rd_status;
  logic [1:0]  cfg_len;
  logic        cfg_or_mode, cfg_auto_stop;
  logic [15:0] cfg_gap;
  logic        rd_req, rd_valid, flag_clear, match_flag, busy;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  status_poll_matcher uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .poll_start(poll_start),
    .poll_abort(poll_abort), .cfg_mask(cfg_mask), .cfg_match(cfg_match),
    .cfg_len(cfg_len), .cfg_or_mode(cfg_or_mode), .cfg_auto_stop(cfg_auto_stop),
    .cfg_gap(cfg_gap), .rd_req(rd_req), .rd_valid(rd_valid),
    .rd_status(rd_status), .flag_clear(flag_clear), .match_flag(match_flag),
    .busy(busy)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic pulse_start();
    poll_start = 1'b1;
    @(negedge clk);
    poll_start = 1'b0;
  endtask

  task automatic respond(input logic [31:0] st, input logic clr);
    rd_valid   = 1'b1;
    rd_status  = st;
    flag_clear = clr;
    @(negedge clk);
    rd_valid   = 1'b0;
    flag_clear = 1'b0;
  endtask

  task automatic serve(input logic [31:0] st, input logic clr);
    while (!rd_req) @(negedge clk);
    @(negedge clk);
    poll_abort = 1'b0;
    respond(st, clr);
  endtask

  task automatic clear_flag();
    flag_clear = 1'b1;
    @(negedge clk);
    flag_clear = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    int gap_cnt;
    int req_cnt;
    rst_n = 1'b0; enable = 1'b1; poll_start = 1'b0; poll_abort = 1'b0;
    cfg_mask = '0; cfg_match = '0; cfg_len = 2'd3; cfg_or_mode = 1'b0;
    cfg_auto_stop = 1'b1; cfg_gap = '0; rd_valid = 1'b0; rd_status = '0;
    flag_clear = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 busy in reset", {31'b0, busy}, 32'd0);
    chk("R1 rd_req in reset", {31'b0, rd_req}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flag after reset", {31'b0, match_flag}, 32'd0);
    chk("R1 busy after reset", {31'b0, busy}, 32'd0);

    // vector table: one read per entry, automatic stop on
    for (int i = 0; i < NVEC; i++) begin
      string tag;
      logic  exp;
      cfg_mask      = VEC[i][99:68];
      cfg_match     = VEC[i][67:36];
      cfg_len       = VEC[i][3:2];
      cfg_or_mode   = VEC[i][1];
      exp           = VEC[i][0];
      cfg_auto_stop = 1'b1;
      cfg_gap       = '0;
      tag = (cfg_len != 2'd3) ? "R3 byte window" : (cfg_or_mode ? "R5 any-bit" : "R4 all-bits");
      pulse_start();
      chk("R2 request after start", {30'b0, busy, rd_req}, 32'd3);
      serve(VEC[i][35:4], 1'b0);
      chk(tag, {31'b0, match_flag}, {31'b0, exp});
      chk("R7 busy after read", {31'b0, busy}, {31'b0, ~exp});
      if (busy) begin
        poll_abort = 1'b1;
        serve(VEC[i][35:4], 1'b0);
        chk("R10 abort after read", {31'b0, busy}, 32'd0);
      end
      clear_flag();
      chk("R9 cleared", {31'b0, match_flag}, 32'd0);
    end

    // R6 gap length, R8 repeated hits, R9 clear priority
    cfg_mask = 32'hFFFF_FFFF; cfg_match = '0; cfg_len = 2'd3; cfg_or_mode = 1'b0;
    cfg_auto_stop = 1'b0;
    foreach (cfg_gap[k]) ;
    for (int g = 0; g < 3; g++) begin
      logic [15:0] want;
      want = (g == 0) ? 16'd5 : ((g == 1) ? 16'd0 : 16'd1);
      cfg_gap = want;
      if (g == 0) pulse_start();
      serve(32'h1, 1'b0);
      gap_cnt = 0;
      while (!rd_req && gap_cnt < 100) begin
        gap_cnt++;
        @(negedge clk);
      end
      chk("R6 gap cycles", gap_cnt, {16'b0, want});
    end
    serve(32'h0, 1'b0);
    chk("R8 flag on hit", {31'b0, match_flag}, 32'd1);
    chk("R8 still polling", {31'b0, busy}, 32'd1);
    clear_flag();
    chk("R9 clear", {31'b0, match_flag}, 32'd0);
    serve(32'h0, 1'b0);
    chk("R8 flag again", {31'b0, match_flag}, 32'd1);
    clear_flag();
    serve(32'h0, 1'b1);
    chk("R9 hit beats clear", {31'b0, match_flag}, 32'd1);
    clear_flag();

    // R10 abort during the gap
    cfg_gap = 16'd200;
    serve(32'h1, 1'b0);
    chk("R10 in gap", {31'b0, busy}, 32'd1);
    poll_abort = 1'b1;
    @(negedge clk);
    poll_abort = 1'b0;
    chk("R10 abort in gap", {31'b0, busy}, 32'd0);

    // R10 abort while a read is outstanding
    cfg_gap = '0;
    pulse_start();
    @(negedge clk);
    poll_abort = 1'b1;
    @(negedge clk);
    poll_abort = 1'b0;
    chk("R10 held while read open", {31'b0, busy}, 32'd1);
    respond(32'h0, 1'b0);
    chk("R10 busy after read", {31'b0, busy}, 32'd0);
    chk("R10 read still counted", {31'b0, match_flag}, 32'd1);
    clear_flag();

    // R7 no requests after automatic stop
    cfg_auto_stop = 1'b1;
    pulse_start();
    serve(32'h0, 1'b0);
    req_cnt = 0;
    for (int c = 0; c < 10; c++) begin
      if (rd_req || busy) req_cnt++;
      @(negedge clk);
    end
    chk("R7 quiet after stop", req_cnt, 32'd0);
    clear_flag();

    // R11 disable
    cfg_auto_stop = 1'b0;
    cfg_gap = 16'd200;
    pulse_start();
    serve(32'h1, 1'b0);
    enable = 1'b0;
    @(negedge clk);
    chk("R11 disable idles", {30'b0, busy, rd_req}, 32'd0);
    pulse_start();
    chk("R11 start ignored", {30'b0, busy, rd_req}, 32'd0);

    // R12 stray strobes
    respond(32'h0, 1'b0);
    chk("R12 strobe while disabled", {31'b0, match_flag}, 32'd0);
    enable = 1'b1;
    @(negedge clk);
    respond(32'h0, 1'b0);
    chk("R12 strobe while idle", {31'b0, match_flag}, 32'd0);

    finish_run();
  end
endmodule